// File: doc/BRIEF.md
# Clock Generator Configuration Target on a Two-Wire Serial Bus

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (SCL, SDA) and holds eight 8-bit control bytes. The bus lines are oversampled by a fast system clock, and SDA is driven low through an open-drain enable. The first byte after the address is a command code. It chooses between two access types. A single-byte access goes to the offset named in the command. A block access always starts at offset 0 and carries a byte count ahead of its data.

The control bytes drive parallel outputs for the rest of the chip: four output-pair enables, a spread-spectrum on/off bit, a spread-depth select and an output-frequency select. The ID byte holds a revision nibble and a vendor nibble, and software cannot change it. All bytes come out of reset with defaults that already give a working clock, so a system may leave the bus unused.

Top module: `twi_clkcfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 7'h69 (8'hD2 for writes, 8'hD3 for reads). Any other address is NACKed, the rest of that transfer is ignored, and no byte changes.
- R2: In the command byte, bit 7 = 1 selects a single-byte access and bit 7 = 0 selects a block access. Bits 6:5 must be 00. A block command must have bits 4:0 = 00000. A command that breaks either rule is NACKed and changes nothing.
- R3: A single-byte write is address+W, command {1,00,offset}, then one data byte. The data byte is stored at that offset.
- R4: A single-byte read is address+W, command, repeated start, address+R. The target returns the byte at the commanded offset. Offsets 8 to 31 read as 8'h00.
- R5: A block write is address+W, command 8'h00, a byte count, then data bytes stored at offsets 0, 1, 2 and so on. A stop after any whole data byte keeps every byte that has already been stored.
- R6: A block read is address+W, command 8'h00, repeated start, address+R. The target returns a count byte equal to 8, then bytes 0 to 7 in ascending order.
- R7: After reset, byte 2 = 8'h83, byte 3 = 8'h0F, and byte 7 = {revision, vendor} = 8'h13. Every other byte is 8'h00.
- R8: Only byte 2 bits 7, 1, 0 and byte 3 bits 3:0 can be written. Writes to all other bits, including all of byte 7, are ignored.
- R9: The outputs follow the stored bytes:
  - out_en[3:0] = byte 3 bits 3:0 (0 = pair in high impedance).
  - freq_sel = byte 2 bit 0 (0 = 100 MHz, 1 = 200 MHz).
  - ss_en = byte 2 bit 1.
  - ss_depth = byte 2 bit 7 (0 = -0.35 %, 1 = -0.5 %).
  - The outputs change only in the cycle after a stored write.
- R10: The target changes sda_oe only while SCL is low. It detects start and stop as SDA edges while SCL is high. It ignores an SCL or SDA pulse shorter than FILT_LEN system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| out_en | output | NUM_OUT | Enable per output pair, 0 = high impedance |
| freq_sel | output | 1 | Output frequency, 0 = 100 MHz, 1 = 200 MHz |
| ss_en | output | 1 | Spread spectrum on |
| ss_depth | output | 1 | Spread depth, 0 = -0.35 %, 1 = -0.5 % |

## Verification
Directed transfers cover each of the four access shapes once.
- A block read straight after reset shows the count prefix and the full default map.
- A block write of eight random bytes, read back as a block, separates the write masks from plain storage.
- A block write stopped after four data bytes shows that the bytes already stored are kept and the later bytes are untouched.

Malformed transfers check that a rejection leaves every register and output unchanged. These are a foreign address, a nonzero chip-select field, a block command with an offset, and a read beyond the map. A single-cycle SCL spike inside a data bit shows whether the filter keeps the bit count aligned. Seeded random single-byte writes and reads at random offsets, checked against a bench model, mix all masks and outputs.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK} phase_t;
  typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_CNT, RL_DATA} role_t;

  localparam int CTL_IDX = 2;
  localparam int EN_IDX  = 3;
  localparam int ID_IDX  = 7;

  // writable bits per byte
  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      CTL_IDX: wr_mask = 8'h83;
      EN_IDX:  wr_mask = 8'h0F;
      default: wr_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx, input logic [7:0] id_byte);
    case (idx)
      CTL_IDX: rst_val = 8'h83;
      EN_IDX:  rst_val = 8'h0F;
      ID_IDX:  rst_val = id_byte;
      default: rst_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      dout_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        dout_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dout = dout_q;

  // R10
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_q != $past(dout_q)) |-> ($past(sync_q[1]) == dout_q));
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

  // R10
  bus_event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_det, stop_det}));
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_cfg_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter int          AW       = 5,
  parameter int          NUM_OUT  = 4,
  parameter logic [7:0]  ID_BYTE  = 8'h13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] out_en,
  output logic               freq_sel,
  output logic               ss_en,
  output logic               ss_depth
);
  logic [7:0] regs_q [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst) begin
        regs_q[i] <= rst_val(i, ID_BYTE);
      end else if (wr_en && wr_addr == AW'(i)) begin
        regs_q[i] <= (regs_q[i] & ~wr_mask(i)) | (wr_data & wr_mask(i));
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs_q[i];
    end
  end

  assign out_en   = regs_q[EN_IDX][NUM_OUT-1:0];
  assign freq_sel = regs_q[CTL_IDX][0];
  assign ss_en    = regs_q[CTL_IDX][1];
  assign ss_depth = regs_q[CTL_IDX][7];

  // R8
  oob_write_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=>
      ($stable(regs_q[EN_IDX]) && $stable(regs_q[CTL_IDX])));
endmodule

// File: rtl/tw_target_fsm.sv
module tw_target_fsm
  import tw_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         AW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr
);
  phase_t        phase_q;
  role_t         role_q;
  logic [7:0]    shreg_q;
  logic [3:0]    bit_q;
  logic [AW-1:0] ptr_q;
  logic          cnt_pend_q, go_tx_q, acked_q, addr_ok_q, oe_q;
  logic          acc_ok;
  logic [7:0]    tx_byte;
  logic [AW-1:0] nxt_ptr;

  always_comb begin
    case (role_q)
      RL_ADDR: acc_ok = (shreg_q[7:1] == ADDR7);
      RL_CMD:  acc_ok = (shreg_q[6:5] == 2'b00) && (shreg_q[7] || shreg_q[4:0] == 5'd0);
      default: acc_ok = 1'b1;
    endcase
  end

  assign tx_byte = cnt_pend_q ? 8'(NUM_REGS) : rd_data;
  assign nxt_ptr = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      role_q     <= RL_ADDR;
      shreg_q    <= '0;
      bit_q      <= '0;
      ptr_q      <= '0;
      cnt_pend_q <= 1'b0;
      go_tx_q    <= 1'b0;
      acked_q    <= 1'b0;
      addr_ok_q  <= 1'b0;
      oe_q       <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase_q   <= PH_RX;
        role_q    <= RL_ADDR;
        bit_q     <= '0;
        oe_q      <= 1'b0;
        addr_ok_q <= 1'b0;
      end else if (stop_det) begin
        phase_q   <= PH_IDLE;
        oe_q      <= 1'b0;
        addr_ok_q <= 1'b0;
      end else begin
        case (phase_q)
          PH_RX: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[6:0], sda_f};
              bit_q   <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (acc_ok) begin
                oe_q    <= 1'b1;
                phase_q <= PH_RX_ACK;
                go_tx_q <= 1'b0;
                case (role_q)
                  RL_ADDR: begin
                    addr_ok_q <= 1'b1;
                    go_tx_q   <= shreg_q[0];
                    role_q    <= RL_CMD;
                  end
                  RL_CMD: begin
                    ptr_q      <= shreg_q[7] ? shreg_q[AW-1:0] : '0;
                    cnt_pend_q <= ~shreg_q[7];
                    role_q     <= shreg_q[7] ? RL_DATA : RL_CNT;
                  end
                  RL_CNT: begin
                    cnt_pend_q <= 1'b0;
                    role_q     <= RL_DATA;
                  end
                  default: begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr_q;
                    wr_data <= shreg_q;
                    ptr_q   <= nxt_ptr;
                  end
                endcase
              end else begin
                phase_q   <= PH_IDLE;
                addr_ok_q <= 1'b0;
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (go_tx_q) begin
                phase_q <= PH_TX;
                shreg_q <= tx_byte;
                oe_q    <= ~tx_byte[7];
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else            ptr_q      <= nxt_ptr;
              end else begin
                phase_q <= PH_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              bit_q <= bit_q + 1'b1;
              if (bit_q == 4'd7) begin
                oe_q    <= 1'b0;
                phase_q <= PH_TX_ACK;
              end else begin
                oe_q    <= ~shreg_q[6];
                shreg_q <= {shreg_q[6:0], 1'b0};
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              acked_q <= ~sda_f;
            end else if (scl_fall) begin
              bit_q <= '0;
              if (acked_q) begin
                phase_q <= PH_TX;
                shreg_q <= tx_byte;
                oe_q    <= ~tx_byte[7];
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else            ptr_q      <= nxt_ptr;
              end else begin
                phase_q   <= PH_IDLE;
                addr_ok_q <= 1'b0;
              end
            end
          end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe  = oe_q;
  assign rd_addr = ptr_q;

  // R10
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> !scl_f);

  // R1
  write_needs_addr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> addr_ok_q);
endmodule

// File: rtl/twi_clkcfg_target.sv
module twi_clkcfg_target #(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         NUM_OUT  = 4,
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] REV_CODE = 4'h1,
  parameter logic [3:0] VEND_ID  = 4'h3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] out_en,
  output logic               freq_sel,
  output logic               ss_en,
  output logic               ss_depth
);
  localparam int         AW      = 5;
  localparam logic [7:0] ID_BYTE = {REV_CODE, VEND_ID};

  logic          scl_f, sda_f;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  tw_line_filter #(.FILT_LEN(FILT_LEN)) scl_filt_i (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));
  tw_line_filter #(.FILT_LEN(FILT_LEN)) sda_filt_i (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));

  tw_cond_detect det_i (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  tw_target_fsm #(.ADDR7(ADDR7), .NUM_REGS(NUM_REGS), .AW(AW)) fsm_i (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr));

  tw_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW), .NUM_OUT(NUM_OUT), .ID_BYTE(ID_BYTE)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_en(out_en), .freq_sel(freq_sel), .ss_en(ss_en), .ss_depth(ss_depth));

  // R9
  outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable({out_en, freq_sel, ss_en, ss_depth}));
endmodule

// File: tb/twi_clkcfg_target_tb_top.sv
module twi_clkcfg_target_tb_top;
  localparam int Q = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, freq_sel, ss_en, ss_depth;
  logic [3:0] out_en;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [8];

  always #10 clk = ~clk;

  twi_clkcfg_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .out_en(out_en), .freq_sel(freq_sel), .ss_en(ss_en), .ss_depth(ss_depth));

  function automatic logic [7:0] m_mask(input int i);
    if (i == 2) return 8'h83;
    if (i == 3) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_rst(input int i);
    if (i == 2) return 8'h83;
    if (i == 3) return 8'h0F;
    if (i == 7) return 8'h13;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    sda_m = b;
    if (glitch) begin
      repeat (5) @(negedge clk);
      scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
      repeat (Q - 6) @(negedge clk);
    end else wq();
    scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch && i == 4);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      d[i] = sda_bus;
      wq(); scl_m = 1'b0; wq();
    end
    put_bit(nack, 1'b0);
  endtask

  task automatic byte_wr(input logic [7:0] a8, input logic [7:0] cmd, input logic [7:0] d,
                         input logic glitch, output logic [2:0] acks);
    bus_start();
    put_byte(a8, 1'b0, acks[2]);
    put_byte(cmd, 1'b0, acks[1]);
    put_byte(d, glitch, acks[0]);
    bus_stop();
  endtask

  task automatic byte_rd(input logic [4:0] off, output logic [7:0] d);
    logic a;
    bus_start();
    put_byte(8'hD2, 1'b0, a);
    put_byte({3'b100, off}, 1'b0, a);
    bus_start();
    put_byte(8'hD3, 1'b0, a);
    get_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic blk_rd(output logic [7:0] cnt, output logic [7:0] v [8]);
    logic a;
    bus_start();
    put_byte(8'hD2, 1'b0, a);
    put_byte(8'h00, 1'b0, a);
    bus_start();
    put_byte(8'hD3, 1'b0, a);
    get_byte(1'b0, cnt);
    for (int i = 0; i < 8; i++) get_byte(i == 7, v[i]);
    bus_stop();
  endtask

  task automatic mdl_wr(input int i, input logic [7:0] d);
    if (i < 8) mdl[i] = (mdl[i] & ~m_mask(i)) | (d & m_mask(i));
  endtask

  task automatic chk_outs(input string req);
    chk(req, {28'd0, out_en}, {28'd0, mdl[3][3:0]});
    chk(req, {29'd0, freq_sel, ss_en, ss_depth}, {29'd0, mdl[2][0], mdl[2][1], mdl[2][7]});
  endtask

  task automatic chk_all_bytes(input string req);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      byte_rd(5'(i), d);
      chk(req, {24'd0, d}, {24'd0, mdl[i]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d, cnt, a8;
    logic [7:0] v [8];
    logic a;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 8; i++) mdl[i] = m_rst(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R7 R9 reset state
    chk("R7 oe", {31'd0, sda_oe}, 32'd0);
    chk_outs("R9 reset outputs");

    // R6 R7 block read of defaults
    blk_rd(cnt, v);
    chk("R6 count", {24'd0, cnt}, 32'd8);
    for (int i = 0; i < 8; i++) chk("R7 default", {24'd0, v[i]}, {24'd0, mdl[i]});

    // R3 R9 single byte write
    byte_wr(8'hD2, 8'h83, 8'h05, 1'b0, acks);
    mdl_wr(3, 8'h05);
    chk("R3 acks", {29'd0, acks}, 32'd7);
    chk_outs("R9 after write");
    byte_rd(5'd3, d);
    chk("R4 readback", {24'd0, d}, {24'd0, mdl[3]});

    // R8 masked and read-only bytes
    byte_wr(8'hD2, 8'h87, 8'hFF, 1'b0, acks); mdl_wr(7, 8'hFF);
    byte_wr(8'hD2, 8'h80, 8'hFF, 1'b0, acks); mdl_wr(0, 8'hFF);
    byte_wr(8'hD2, 8'h82, 8'h7C, 1'b0, acks); mdl_wr(2, 8'h7C);
    chk_all_bytes("R8 masked bytes");
    chk_outs("R9 ctl cleared");

    // R1 foreign address
    byte_wr(8'hD4, 8'h83, 8'h0A, 1'b0, acks);
    chk("R1 nack foreign addr", {29'd0, acks}, 32'd0);
    chk_outs("R1 no change");

    // R2 nonzero chip select and block with offset
    byte_wr(8'hD2, 8'hA3, 8'h0A, 1'b0, acks);
    chk("R2 cs nack", {29'd0, acks}, 32'b100);
    byte_wr(8'hD2, 8'h03, 8'h0A, 1'b0, acks);
    chk("R2 block offset nack", {29'd0, acks}, 32'b100);
    chk_outs("R2 no change");

    // R4 beyond map
    byte_rd(5'd20, d);
    chk("R4 out of map", {24'd0, d}, 32'd0);

    // R5 full block write
    bus_start();
    put_byte(8'hD2, 1'b0, a);
    put_byte(8'h00, 1'b0, a);
    put_byte(8'h08, 1'b0, a);
    chk("R5 count ack", {31'd0, a}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      d = 8'($urandom);
      put_byte(d, 1'b0, a);
      mdl_wr(i, d);
    end
    bus_stop();
    blk_rd(cnt, v);
    chk("R6 count again", {24'd0, cnt}, 32'd8);
    for (int i = 0; i < 8; i++) chk("R5 block data", {24'd0, v[i]}, {24'd0, mdl[i]});
    chk_outs("R9 after block");

    // R5 early stop after four bytes
    bus_start();
    put_byte(8'hD2, 1'b0, a);
    put_byte(8'h00, 1'b0, a);
    put_byte(8'h08, 1'b0, a);
    for (int i = 0; i < 4; i++) begin
      d = (i == 2) ? 8'h81 : 8'h0C;
      put_byte(d, 1'b0, a);
      mdl_wr(i, d);
    end
    bus_stop();
    chk_all_bytes("R5 early stop");

    // R10 short SCL spike inside a data bit
    byte_wr(8'hD2, 8'h83, 8'h09, 1'b1, acks);
    mdl_wr(3, 8'h09);
    chk("R10 glitch acks", {29'd0, acks}, 32'd7);
    byte_rd(5'd3, d);
    chk("R10 glitch data", {24'd0, d}, {24'd0, mdl[3]});

    // R3 R4 R9 random single-byte traffic
    for (int k = 0; k < 10; k++) begin
      int off;
      off = int'($urandom % 8);
      d = 8'($urandom);
      a8 = {3'b100, 5'(off)};
      byte_wr(8'hD2, a8, d, 1'b0, acks);
      mdl_wr(off, d);
      chk("R3 random acks", {29'd0, acks}, 32'd7);
      byte_rd(5'(off), d);
      chk("R4 random read", {24'd0, d}, {24'd0, mdl[off]});
      chk_outs("R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule